// File: doc/BRIEF.md
# Nibble Accumulator ALU with Carry and Zero Flags

This block is the arithmetic core of a 4-bit accumulator machine. It holds the accumulator, the carry flag and the zero flag. Each cycle in which `op_valid` is high, it applies one operation to them. The operands are the accumulator, a data-memory nibble (`mem_in`), a 4-bit immediate (`imm_in`) and the carry flag. Each operation follows its own rule for which flags it writes.

Memory increment and decrement use the same adder as the accumulator operations. The incremented or decremented nibble appears combinationally on `mem_result`, and `mem_we` is raised in that same cycle so that the surrounding datapath can write it back. Register-file and memory addressing belong to the surrounding datapath and are not part of this block.

Top module: `acc_nibble_alu`

## Requirements
- R1: While `rst_n` is low, and after the first rising clock edge in that state, the accumulator is 0, the carry flag is 0 and the zero flag is 0.
- R2: A cycle with `op_valid` low, with code 0 (no-op), or with any code from 20 to 31 leaves the accumulator and both flags unchanged.
- R3: Operations are selected by `op_code` with these values:
  - 1 clear accumulator, 2 clear carry, 3 set carry, 4 complement
  - 5 increment accumulator, 6 decrement accumulator, 7 rotate left through carry
  - 8 add memory, 9 add memory with carry, 10 decimal adjust after addition, 11 decimal adjust after subtraction
  - 12 XOR with memory, 13 AND with memory, 14 OR with memory
  - 15 compare with memory, 16 compare with immediate, 17 load immediate
  - 18 increment memory, 19 decrement memory
  
  Each operation takes effect on the rising edge at which it is presented.
- R4: The add operation sets the accumulator to (accumulator + memory) mod 16. Add with carry also adds the carry flag. For both, the carry flag becomes the carry out of bit 3.
- R5: Accumulator increment sets the carry flag when the old value was 15. Accumulator decrement sets the carry flag when the old value was non-zero, and clears it when the value wraps from 0 to 15.
- R6: For memory increment and decrement, `mem_result` equals `mem_in` ± 1 mod 16 in the same cycle and `mem_we` is high. The flags follow the R5 rules applied to `mem_in`, and the accumulator is unchanged. `mem_we` is low for every other cycle.
- R7: Compare with memory leaves the accumulator unchanged and sets the flags as follows:
  - memory > accumulator: carry 0, zero 0
  - memory = accumulator: carry 1, zero 1
  - memory < accumulator: carry 1, zero 0
  
  Compare with immediate does the same with `imm_in` in place of memory.
- R8: Decimal adjust after addition adds 6 to the accumulator (mod 16), and decimal adjust after subtraction adds 10 (mod 16). Both leave the carry flag unchanged.
- R9: Rotate left through carry moves the old carry into bit 0, moves bit n into bit n+1, and moves bit 3 into the carry flag.
- R10: XOR, OR, complement and load immediate update the zero flag and keep the carry flag. AND changes only the accumulator.
- R11: Clear accumulator writes 0 to the accumulator and keeps the carry flag. Clear carry and set carry write only the carry flag.
- R12: Every operation that writes the zero flag sets it exactly when its 4-bit result is 0000. These are:
  - clear accumulator, complement, increment and decrement of the accumulator, rotate left through carry
  - add, add with carry, both decimal adjusts
  - XOR, OR, load immediate
  - both compares
  - memory increment and decrement

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Apply `op_code` this cycle |
| op_code | input | 5 | Operation select (R3) |
| mem_in | input | 4 | Memory operand nibble |
| imm_in | input | 4 | Immediate operand nibble |
| acc_q | output | 4 | Accumulator |
| cf_q | output | 1 | Carry flag |
| zf_q | output | 1 | Zero flag |
| mem_result | output | 4 | Incremented or decremented memory nibble |
| mem_we | output | 1 | Write-back strobe for `mem_result` |

## Verification
From the ports, the hardest condition to reach is a particular old carry combined with a particular accumulator value: the carry only takes the wanted value as a side effect of an earlier operation, and load immediate disturbs the zero flag. The stimulus therefore builds every starting state with a preamble of two operations: a load immediate of the chosen accumulator value, followed by clear carry or set carry. It then applies each operation against all 16 memory values with both carry states, so that the wrap points are reached exhaustively. These include increment from 15, decrement from 0, the equal case of the compares, and the carry into the rotate.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam logic [4:0] OP_NOP  = 5'd0;
    localparam logic [4:0] OP_CLA  = 5'd1;
    localparam logic [4:0] OP_CLC  = 5'd2;
    localparam logic [4:0] OP_STC  = 5'd3;
    localparam logic [4:0] OP_CPL  = 5'd4;
    localparam logic [4:0] OP_INCA = 5'd5;
    localparam logic [4:0] OP_DECA = 5'd6;
    localparam logic [4:0] OP_RLC  = 5'd7;
    localparam logic [4:0] OP_ADD  = 5'd8;
    localparam logic [4:0] OP_ADC  = 5'd9;
    localparam logic [4:0] OP_DADJ = 5'd10;
    localparam logic [4:0] OP_DSBJ = 5'd11;
    localparam logic [4:0] OP_XOR  = 5'd12;
    localparam logic [4:0] OP_AND  = 5'd13;
    localparam logic [4:0] OP_OR   = 5'd14;
    localparam logic [4:0] OP_CMPM = 5'd15;
    localparam logic [4:0] OP_CMPI = 5'd16;
    localparam logic [4:0] OP_LDI  = 5'd17;
    localparam logic [4:0] OP_INCM = 5'd18;
    localparam logic [4:0] OP_DECM = 5'd19;

    typedef enum logic [1:0] {
        LG_XOR = 2'd0,
        LG_AND = 2'd1,
        LG_OR  = 2'd2,
        LG_NOT = 2'd3
    } lg_sel_e;

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         ci_i,
    output logic [W-1:0] sum_o,
    output logic         co_o
);
    logic [W:0] carry;

    assign carry[0] = ci_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i]     = a_i[i] ^ b_i[i] ^ carry[i];
        assign carry[i + 1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
    end

    assign co_o = carry[W];
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  lg_sel_e      sel_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    always_comb begin
        case (sel_i)
            LG_XOR:  y_o = a_i ^ b_i;
            LG_AND:  y_o = a_i & b_i;
            LG_OR:   y_o = a_i | b_i;
            default: y_o = ~a_i;
        endcase
    end
endmodule

// File: rtl/acc_nibble_alu.sv
module acc_nibble_alu
    import acc_alu_pkg::*;
#(
    parameter int DW      = 4,
    parameter int ADJ_ADD = 6,
    parameter int ADJ_SUB = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [4:0]    op_code,
    input  logic [DW-1:0] mem_in,
    input  logic [DW-1:0] imm_in,
    output logic [DW-1:0] acc_q,
    output logic          cf_q,
    output logic          zf_q,
    output logic [DW-1:0] mem_result,
    output logic          mem_we
);
    localparam logic [DW-1:0] K_ADD = ADJ_ADD[DW-1:0];
    localparam logic [DW-1:0] K_SUB = ADJ_SUB[DW-1:0];
    localparam logic [DW-1:0] ONES  = {DW{1'b1}};

    typedef struct packed {
        logic [DW-1:0] acc;
        logic          cf;
        logic          zf;
    } alu_st_t;

    alu_st_t st_d, st_q;

    logic [DW-1:0] add_a, add_b, add_sum;
    logic          add_ci, add_co;
    lg_sel_e       lg_sel;
    logic [DW-1:0] lg_y;

    function automatic logic is_zero(input logic [DW-1:0] v);
        return ~|v;
    endfunction

    // Operand selection for the shared adder and logic unit
    always_comb begin
        add_a  = st_q.acc;
        add_b  = '0;
        add_ci = 1'b0;
        lg_sel = LG_XOR;
        case (op_code)
            OP_INCA: add_ci = 1'b1;
            OP_DECA: add_b  = ONES;
            OP_ADD:  add_b  = mem_in;
            OP_ADC: begin
                add_b  = mem_in;
                add_ci = st_q.cf;
            end
            OP_DADJ: add_b = K_ADD;
            OP_DSBJ: add_b = K_SUB;
            OP_CMPM: begin
                add_b  = ~mem_in;
                add_ci = 1'b1;
            end
            OP_CMPI: begin
                add_b  = ~imm_in;
                add_ci = 1'b1;
            end
            OP_INCM: begin
                add_a  = mem_in;
                add_ci = 1'b1;
            end
            OP_DECM: begin
                add_a = mem_in;
                add_b = ONES;
            end
            OP_AND:  lg_sel = LG_AND;
            OP_OR:   lg_sel = LG_OR;
            OP_CPL:  lg_sel = LG_NOT;
            default: lg_sel = LG_XOR;
        endcase
    end

    acc_alu_adder #(.W(DW)) i_adder (
        .a_i   (add_a),
        .b_i   (add_b),
        .ci_i  (add_ci),
        .sum_o (add_sum),
        .co_o  (add_co)
    );

    acc_alu_logic #(.W(DW)) i_logic (
        .sel_i (lg_sel),
        .a_i   (st_q.acc),
        .b_i   (mem_in),
        .y_o   (lg_y)
    );

    // Next-state computation
    always_comb begin
        st_d = st_q;
        if (op_valid) begin
            case (op_code)
                OP_CLA: begin
                    st_d.acc = '0;
                    st_d.zf  = 1'b1;
                end
                OP_CLC: st_d.cf = 1'b0;
                OP_STC: st_d.cf = 1'b1;
                OP_RLC: begin
                    st_d.acc = {st_q.acc[DW-2:0], st_q.cf};
                    st_d.cf  = st_q.acc[DW-1];
                    st_d.zf  = is_zero({st_q.acc[DW-2:0], st_q.cf});
                end
                OP_INCA, OP_DECA, OP_ADD, OP_ADC: begin
                    st_d.acc = add_sum;
                    st_d.cf  = add_co;
                    st_d.zf  = is_zero(add_sum);
                end
                OP_DADJ, OP_DSBJ: begin
                    st_d.acc = add_sum;
                    st_d.zf  = is_zero(add_sum);
                end
                OP_XOR, OP_OR, OP_CPL: begin
                    st_d.acc = lg_y;
                    st_d.zf  = is_zero(lg_y);
                end
                OP_AND: st_d.acc = lg_y;
                OP_CMPM, OP_CMPI, OP_INCM, OP_DECM: begin
                    st_d.cf = add_co;
                    st_d.zf = is_zero(add_sum);
                end
                OP_LDI: begin
                    st_d.acc = imm_in;
                    st_d.zf  = is_zero(imm_in);
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_q      = st_q.acc;
    assign cf_q       = st_q.cf;
    assign zf_q       = st_q.zf;
    assign mem_result = add_sum;
    assign mem_we     = op_valid && (op_code == OP_INCM || op_code == OP_DECM);

endmodule

// File: rtl/acc_nibble_alu_chk.sv
module acc_nibble_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int DW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [4:0]    op_code,
    input logic [DW-1:0] mem_in,
    input logic [DW-1:0] imm_in,
    input logic [DW-1:0] acc_q,
    input logic          cf_q,
    input logic          zf_q,
    input logic          mem_we
);
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(acc_q) && $stable(cf_q) && $stable(zf_q)); // R2

    AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == OP_INCA && acc_q == {DW{1'b1}} |=> cf_q && zf_q); // R5

    AST_MEMOP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> $stable(acc_q)); // R6

    AST_CMP_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == OP_CMPM && mem_in == acc_q |=> cf_q && zf_q && $stable(acc_q)); // R7

    AST_ADJ_KEEPS_CF: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_code == OP_DADJ || op_code == OP_DSBJ) |=> $stable(cf_q)); // R8

    AST_AND_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == OP_AND |=> $stable(cf_q) && $stable(zf_q)); // R10

    AST_CLC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == OP_CLC |=> !cf_q); // R11

    AST_LDI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == OP_LDI |=> acc_q == $past(imm_in) && zf_q == (acc_q == '0)); // R12
endmodule

bind acc_nibble_alu acc_nibble_alu_chk #(.DW(DW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .mem_in   (mem_in),
    .imm_in   (imm_in),
    .acc_q    (acc_q),
    .cf_q     (cf_q),
    .zf_q     (zf_q),
    .mem_we   (mem_we)
);

// File: tb/test_acc_nibble_alu.sv
module test_acc_nibble_alu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_code = 5'd0;
    logic [3:0] mem_in = 4'd0;
    logic [3:0] imm_in = 4'd0;
    logic [3:0] acc_q;
    logic       cf_q, zf_q;
    logic [3:0] mem_result;
    logic       mem_we;

    int total = 0;
    int bad = 0;
    logic [3:0] ea = 4'd0;
    logic       ec = 1'b0;
    logic       ez = 1'b0;

    always #2.5 clk = ~clk;

    acc_nibble_alu i_acc_nibble_alu (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .mem_in     (mem_in),
        .imm_in     (imm_in),
        .acc_q      (acc_q),
        .cf_q       (cf_q),
        .zf_q       (zf_q),
        .mem_result (mem_result),
        .mem_we     (mem_we)
    );

    function automatic string tag_of(input logic v, input logic [4:0] op);
        if (!v || op == 5'd0 || op > 5'd19) return "R2";
        case (op)
            5'd8, 5'd9:           return "R4";
            5'd5, 5'd6:           return "R5";
            5'd18, 5'd19:         return "R6";
            5'd15, 5'd16:         return "R7";
            5'd10, 5'd11:         return "R8";
            5'd7:                 return "R9";
            5'd12, 5'd13, 5'd14,
            5'd4, 5'd17:          return "R10";
            default:              return "R11";
        endcase
    endfunction

    task automatic check6(input string tag, input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s op=%0d acc/cf/zf actual=%b expected=%b", tag, op_code, act, exp);
        end
    endtask

    task automatic run(input logic v, input logic [4:0] op, input logic [3:0] m, input logic [3:0] im);
        logic [3:0] na;
        logic       nc, nz, nwe;
        logic [3:0] nmr;
        int         s;
        @(negedge clk);
        op_valid = v; op_code = op; mem_in = m; imm_in = im;
        na = ea; nc = ec; nz = ez; nwe = 1'b0; nmr = 4'd0;
        if (v) begin
            case (op)
                5'd1:  begin na = 4'd0; nz = 1'b1; end
                5'd2:  nc = 1'b0;
                5'd3:  nc = 1'b1;
                5'd4:  begin na = ~ea; nz = (na == 0); end
                5'd5:  begin na = ea + 4'd1; nc = (ea == 4'd15); nz = (na == 0); end
                5'd6:  begin na = ea - 4'd1; nc = (ea != 4'd0); nz = (na == 0); end
                5'd7:  begin na = {ea[2:0], ec}; nc = ea[3]; nz = (na == 0); end
                5'd8:  begin s = ea + m; na = 4'(s); nc = (s > 15); nz = (na == 0); end
                5'd9:  begin s = ea + m + ec; na = 4'(s); nc = (s > 15); nz = (na == 0); end
                5'd10: begin na = ea + 4'd6; nz = (na == 0); end
                5'd11: begin na = ea + 4'd10; nz = (na == 0); end
                5'd12: begin na = ea ^ m; nz = (na == 0); end
                5'd13: na = ea & m;
                5'd14: begin na = ea | m; nz = (na == 0); end
                5'd15: begin nc = (ea >= m); nz = (ea == m); end
                5'd16: begin nc = (ea >= im); nz = (ea == im); end
                5'd17: begin na = im; nz = (im == 0); end
                5'd18: begin nwe = 1'b1; nmr = m + 4'd1; nc = (m == 4'd15); nz = (nmr == 0); end
                5'd19: begin nwe = 1'b1; nmr = m - 4'd1; nc = (m != 4'd0); nz = (nmr == 0); end
                default: ;
            endcase
        end
        #1;
        total++;
        if (mem_we !== nwe || (nwe && mem_result !== nmr)) begin
            bad++;
            $display("FAIL R6 op=%0d we/result actual=%b/%h expected=%b/%h",
                     op, mem_we, mem_result, nwe, nmr);
        end
        @(posedge clk);
        #1;
        ea = na; ec = nc; ez = nz;
        check6(tag_of(v, op), {acc_q, cf_q, zf_q}, {ea, ec, ez});
    endtask

    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check6("R1", {acc_q, cf_q, zf_q}, 6'b0);
        @(negedge clk);
        rst_n = 1'b1;
        // R3 R12: every defined code plus one undefined code, all states
        for (int k = 0; k <= 20; k++) begin
            logic [4:0] op;
            op = (k == 20) ? 5'd25 : 5'(k);
            for (int a = 0; a < 16; a++) begin
                for (int m = 0; m < 16; m++) begin
                    for (int c = 0; c < 2; c++) begin
                        run(1'b1, 5'd17, 4'd0, 4'(a));
                        run(1'b1, c ? 5'd3 : 5'd2, 4'd0, 4'd0);
                        run(1'b1, op, 4'(m), 4'(m ^ a ^ k));
                    end
                end
            end
        end
        // R2: valid low with active codes is ignored
        for (int k = 1; k < 20; k++) begin
            run(1'b1, 5'd17, 4'd0, 4'(k));
            run(1'b0, 5'(k), 4'(k), 4'(15 - k));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule